// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects interrupt events for up to `W` sources and gives software a small register window to control them. Each source owns one bit index, and that index is the same in every register of the bank. A one-cycle pulse on an event line latches a pending cause bit. Software removes pending bits in one of two ways, chosen bit by bit in a control register. In write-one-to-clear mode a bit clears when a 1 is written to it. In clear-on-read mode a bit clears as a side effect of a read that returned it.

A mask register hides selected causes from the interrupt line. Software can write the whole mask at once, or it can set or clear single mask bits through two write-only registers without a read-modify-write. A masked view of the causes can be read, and it can also be cleared. A registered interrupt output is high whenever any unmasked cause is pending.

Access goes through a simple port. A request with the write flag set is a write. A request with the write flag clear is a read, and its data appears on `rdata_o` after the next clock edge.

Top module: `irq_cause_bank`

## Requirements
- R1: Word index decode: 0 clear-mode control (read/write), 1 cause, 2 masked cause, 3 cause-set, 4 mask value, 5 mask-set, 6 mask-clear; index 7 is unused, reads 0 and ignores writes. Read data is registered: `rdata_o` carries the addressed value in the cycle after a read request and is 0 after any cycle without a read.
- R2: An event pulse on bit i sets cause bit i on the next edge; it stays set until cleared.
- R3: Writing a 1 to bit i of the cause (index 1) or masked-cause (index 2) register clears cause bit i only when control bit i is 0. When control bit i is 1, the write has no effect on that bit.
- R4: Reading the cause register returns the full cause vector. After the read, cause bits whose control bit is 1 are cleared, and bits whose control bit is 0 are kept.
- R5: Reading the masked-cause register returns cause AND NOT mask. The read clears only the returned bits whose control bit is 1. Masked cause bits stay pending.
- R6: Writing a 1 to a bit of the cause-set register (index 3) sets that cause bit. The register reads back as 0.
- R7: The mask value register (index 4) is read/write. A mask bit of 1 hides that cause.
- R8: A 1 in a mask-set (index 5) bit sets that mask bit, and a 1 in a mask-clear (index 6) bit clears it. Zeros leave the mask unchanged, and both registers read back as 0.
- R9: When an event (or a cause-set write) and a clear hit the same cause bit in one cycle, the bit ends set.
- R10: `irq_o` is a register that holds the OR of (cause AND NOT mask) for the state after each edge.
- R11: Reset sets control and cause to 0, sets the mask to all ones, and drives `irq_o` and `rdata_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Register word index |
| wdata_i | input | W | Write data |
| evt_i | input | W | Event pulses, one per source |
| rdata_o | output | W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that a request carries one operation per cycle and that `addr_i`, `we_i` and `wdata_i` are known whenever `req_i` is high. They also assume that event lines are never X. The stimulus drives every input on the falling edge from defined constants, so each access lasts exactly one cycle. The stimulus covers every clear path together with events on the same bit, because the rule that a set wins over a clear depends on that overlap.

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  evt_i,
  output logic [W-1:0]  rdata_o,
  output logic          irq_o
);

  localparam logic [AW-1:0] IX_CTRL = AW'(0);
  localparam logic [AW-1:0] IX_CAUS = AW'(1);
  localparam logic [AW-1:0] IX_MCAU = AW'(2);
  localparam logic [AW-1:0] IX_SETC = AW'(3);
  localparam logic [AW-1:0] IX_MASK = AW'(4);
  localparam logic [AW-1:0] IX_MSET = AW'(5);
  localparam logic [AW-1:0] IX_MCLR = AW'(6);

  logic [W-1:0] ctrl_q, cause_q, mask_q;
  logic [W-1:0] cause_d, mask_d, masked, rd_val, clr_wr, clr_rd, set_v;
  logic         rd, wr;

  assign rd     = req_i & ~we_i;
  assign wr     = req_i & we_i;
  assign masked = cause_q & ~mask_q;

  always_comb begin
    case (addr_i)
      IX_CTRL: rd_val = ctrl_q;
      IX_CAUS: rd_val = cause_q;
      IX_MCAU: rd_val = masked;
      IX_MASK: rd_val = mask_q;
      default: rd_val = '0;
    endcase
  end

  assign clr_wr = (wr && (addr_i == IX_CAUS || addr_i == IX_MCAU)) ? (wdata_i & ~ctrl_q) : '0;

  always_comb begin
    clr_rd = '0;
    if (rd && addr_i == IX_CAUS) clr_rd = cause_q & ctrl_q;
    if (rd && addr_i == IX_MCAU) clr_rd = masked & ctrl_q;
  end

  assign set_v   = evt_i | ((wr && addr_i == IX_SETC) ? wdata_i : '0);
  assign cause_d = (cause_q & ~(clr_wr | clr_rd)) | set_v;

  always_comb begin
    mask_d = mask_q;
    if (wr) begin
      case (addr_i)
        IX_MASK: mask_d = wdata_i;
        IX_MSET: mask_d = mask_q | wdata_i;
        IX_MCLR: mask_d = mask_q & ~wdata_i;
        default: mask_d = mask_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cause_q <= '0;
      mask_q  <= '1;
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (wr && addr_i == IX_CTRL) ctrl_q <= wdata_i;
      cause_q <= cause_d;
      mask_q  <= mask_d;
      rdata_o <= rd ? rd_val : '0;
      irq_o   <= |(cause_d & ~mask_d);
    end
  end

endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  evt_i,
  input logic [W-1:0]  rdata_o,
  input logic          irq_o,
  input logic [W-1:0]  cause_q,
  input logic [W-1:0]  mask_q,
  input logic [W-1:0]  ctrl_q
);

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i))); // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(cause_q & ~mask_q)); // R10

  AST_MSET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == AW'(5)) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R8

  AST_MCLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == AW'(6)) |=> ((mask_q & $past(wdata_i)) == '0)); // R8

  AST_SET_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && addr_i == AW'(3)) |=> (rdata_o == '0)); // R6

  AST_COR_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == AW'(1) && evt_i == '0)
    |=> ((cause_q & $past(ctrl_q)) == ($past(cause_q) & $past(ctrl_q)))); // R3

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && !we_i) |=> (rdata_o == '0)); // R1

endmodule

bind irq_cause_bank irq_cause_bank_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .evt_i(evt_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .cause_q(cause_q), .mask_q(mask_q), .ctrl_q(ctrl_q)
);

// File: tb/irq_cause_bank_tb.sv
module irq_cause_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, evt_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_cause_bank u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .evt_i(evt_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  ix;
    logic [31:0] wd;
    logic [31:0] ev;
    logic [31:0] xrd;
    logic        xirq;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [1:0] ID = 2'd0, RD = 2'd1, WR = 2'd2;
  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{RD, 3'd0, 32'h0,        32'h0,  32'h0,        1'b0, 8'd11}, // R11
    '{RD, 3'd4, 32'h0,        32'h0,  32'hFFFF_FFFF, 1'b0, 8'd11}, // R11
    '{ID, 3'd0, 32'h0,        32'h5,  32'h0,        1'b0, 8'd2},  // R2
    '{RD, 3'd1, 32'h0,        32'h0,  32'h5,        1'b0, 8'd2},  // R2
    '{RD, 3'd2, 32'h0,        32'h0,  32'h0,        1'b0, 8'd5},  // R5
    '{WR, 3'd6, 32'h1,        32'h0,  32'h0,        1'b1, 8'd8},  // R8
    '{RD, 3'd2, 32'h0,        32'h0,  32'h1,        1'b1, 8'd5},  // R5
    '{RD, 3'd4, 32'h0,        32'h0,  32'hFFFF_FFFE, 1'b1, 8'd8}, // R8
    '{WR, 3'd1, 32'h1,        32'h0,  32'h0,        1'b0, 8'd3},  // R3
    '{RD, 3'd1, 32'h0,        32'h0,  32'h4,        1'b0, 8'd3},  // R3
    '{WR, 3'd0, 32'hF0,       32'h0,  32'h0,        1'b0, 8'd1},  // R1
    '{RD, 3'd0, 32'h0,        32'h0,  32'hF0,       1'b0, 8'd1},  // R1
    '{ID, 3'd0, 32'h0,        32'h30, 32'h0,        1'b0, 8'd2},  // R2
    '{WR, 3'd4, 32'h0,        32'h0,  32'h0,        1'b1, 8'd7},  // R7
    '{WR, 3'd1, 32'h30,       32'h0,  32'h0,        1'b1, 8'd3},  // R3
    '{RD, 3'd1, 32'h0,        32'h0,  32'h34,       1'b1, 8'd4},  // R4
    '{RD, 3'd1, 32'h0,        32'h0,  32'h4,        1'b1, 8'd4},  // R4
    '{WR, 3'd2, 32'h4,        32'h0,  32'h0,        1'b0, 8'd3},  // R3
    '{WR, 3'd3, 32'h81,       32'h0,  32'h0,        1'b1, 8'd6},  // R6
    '{RD, 3'd3, 32'h0,        32'h0,  32'h0,        1'b1, 8'd6},  // R6
    '{WR, 3'd5, 32'h1,        32'h0,  32'h0,        1'b1, 8'd8},  // R8
    '{RD, 3'd2, 32'h0,        32'h0,  32'h80,       1'b0, 8'd5},  // R5
    '{RD, 3'd1, 32'h0,        32'h0,  32'h1,        1'b0, 8'd5},  // R5
    '{WR, 3'd0, 32'h8,        32'h0,  32'h0,        1'b0, 8'd1},  // R1
    '{WR, 3'd1, 32'h1,        32'h0,  32'h0,        1'b0, 8'd3},  // R3
    '{WR, 3'd3, 32'h2,        32'h0,  32'h0,        1'b1, 8'd6},  // R6
    '{WR, 3'd1, 32'h2,        32'h2,  32'h0,        1'b1, 8'd9},  // R9
    '{RD, 3'd1, 32'h0,        32'h0,  32'h2,        1'b1, 8'd9},  // R9
    '{WR, 3'd3, 32'h8,        32'h0,  32'h0,        1'b1, 8'd6},  // R6
    '{RD, 3'd1, 32'h0,        32'h8,  32'hA,        1'b1, 8'd9},  // R9
    '{RD, 3'd1, 32'h0,        32'h0,  32'hA,        1'b1, 8'd4},  // R4
    '{RD, 3'd1, 32'h0,        32'h0,  32'h2,        1'b1, 8'd4},  // R4
    '{WR, 3'd1, 32'h2,        32'h0,  32'h0,        1'b0, 8'd10}, // R10
    '{WR, 3'd4, 32'h0000_F00F, 32'h0, 32'h0,        1'b0, 8'd7},  // R7
    '{WR, 3'd5, 32'h0,        32'h0,  32'h0,        1'b0, 8'd8},  // R8
    '{WR, 3'd6, 32'h0,        32'h0,  32'h0,        1'b0, 8'd8},  // R8
    '{RD, 3'd4, 32'h0,        32'h0,  32'h0000_F00F, 1'b0, 8'd8}, // R8
    '{RD, 3'd7, 32'h0,        32'h0,  32'h0,        1'b0, 8'd1}   // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [2:0] ix, input logic [31:0] wd,
                      input logic [31:0] ev);
    req_i   = (op != ID);
    we_i    = (op == WR);
    addr_i  = ix;
    wdata_i = wd;
    evt_i   = ev;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0; evt_i = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 irq", {31'b0, irq_o}, 32'h0);
    check("R11 rdata", rdata_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op, VEC[i].ix, VEC[i].wd, VEC[i].ev);
      check($sformatf("R%0d vec %0d rdata", VEC[i].rq, i), rdata_o, VEC[i].xrd);
      check($sformatf("R%0d vec %0d irq", VEC[i].rq, i), {31'b0, irq_o}, {31'b0, VEC[i].xirq});
    end
    // R1: write to unused index 7 changes nothing
    step(WR, 3'd7, 32'hFFFF_FFFF, 32'h0);
    step(RD, 3'd0, 32'h0, 32'h0); check("R1 ctrl after idx7 write", rdata_o, 32'h8);
    step(RD, 3'd4, 32'h0, 32'h0); check("R1 mask after idx7 write", rdata_o, 32'h0000_F00F);
    step(RD, 3'd1, 32'h0, 32'h0); check("R1 cause after idx7 write", rdata_o, 32'h0);
    // R11: mid-run reset with pending unmasked cause
    step(WR, 3'd3, 32'h10, 32'h0);
    check("R10 irq before reset", {31'b0, irq_o}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R11 irq after reset", {31'b0, irq_o}, 32'h0);
    step(RD, 3'd1, 32'h0, 32'h0); check("R11 cause after reset", rdata_o, 32'h0);
    step(RD, 3'd0, 32'h0, 32'h0); check("R11 ctrl after reset", rdata_o, 32'h0);
    step(RD, 3'd4, 32'h0, 32'h0); check("R11 mask after reset", rdata_o, 32'hFFFF_FFFF);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule